// File: doc/BRIEF.md
# Burst-of-Two DDR SRAM Controller

This block sits between a simple valid/ready request port and a synchronous static RAM. The RAM has one shared data bus for both directions, moves data on both clock edges, and always transfers a burst of two beats. Each accepted request carries a two-beat write payload with per-beat byte enables, or asks for a two-beat read. Read requests return their data with the tag given at request time.

The controller runs on a clock at twice the memory rate. A phase flag marks each half-cycle as either the main (rising) slot or the complementary slot, and the flag is also driven out so that the memory clocks can be built from it. Commands go out only in main slots, at most one per memory cycle. Write beats are driven two and three half-cycles after the write command. Read beats are sampled five and six half-cycles after the read command, and they are taken only while the memory's data-valid input is high. A write is held back when its beats would meet a read burst that is still returning on the shared bus, or would follow it with no idle half-cycle between them.

Top module: `ddr2b_ctrl`

## Requirements
- R1: Every request transfers exactly two beats. For a write, `mem_oe` is high for exactly two half-cycles. A read response packs beat 0 in `rsp_data[DW-1:0]` and beat 1 in the upper half.
- R2: `mem_rd` and `mem_wr` are never high in the same half-cycle. Either one may be high only in a half-cycle where `mem_kphase` is 1, so all commands fall on the same half-cycle parity and no two commands fall in the same memory cycle.
- R3: For a write command seen in half-cycle h, `mem_oe` is high in h+2, carrying beat 0 (`req_wdata[DW-1:0]`), and in h+3, carrying beat 1. At no other time does a write cause the bus to be driven.
- R4: `mem_be` bit i enables data bits [8i+7:8i]. The enables for beat 0 come from `req_be[BW-1:0]` and those for beat 1 from the upper half, so the two beats of one burst can differ.
- R5: For a read command seen in half-cycle h, `mem_dq_i` is sampled at the end of h+5 (beat 0) and at the end of h+6 (beat 1). `rsp_valid` is high for one half-cycle, in h+7.
- R6: `mem_oe` is low in every half-cycle in which a read beat is due on the bus.
- R7: No write is issued 2 or 4 half-cycles after a read, so a read burst and a later write burst always have at least one idle half-cycle between them on the bus. A read that directly follows a write is not delayed.
- R8: `rsp_tag` returns the tag of the read request. Responses come back in the order the requests were accepted.
- R9: `rsp_err` is 1 when `mem_qvld` was low at either read beat sample, and 0 when it was high at both.
- R10: `req_ready` is low during reset, in every half-cycle with `mem_kphase` = 1, and for a write request while a write would break R7. A request is accepted at a clock edge where `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock at twice the memory rate |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Burst address |
| req_tag | input | TW | Tag returned with the read response |
| req_wdata | input | 2*DW | Write beats, beat 0 in the low half |
| req_be | input | 2*BW | Byte enables, beat 0 in the low half |
| rsp_valid | output | 1 | Read response present for one half-cycle |
| rsp_data | output | 2*DW | Read beats, beat 0 in the low half |
| rsp_tag | output | TW | Tag of the read request |
| rsp_err | output | 1 | A data-valid strobe was missing |
| mem_kphase | output | 1 | 1 in main-edge half-cycles |
| mem_rd | output | 1 | Read command |
| mem_wr | output | 1 | Write command |
| mem_addr | output | AW | Command address |
| mem_dq_o | output | DW | Write beat driven onto the bus |
| mem_be | output | BW | Byte enables of the driven beat |
| mem_oe | output | 1 | Bus driven by the controller |
| mem_dq_i | input | DW | Data returned from the bus |
| mem_qvld | input | 1 | Memory marks the returned beat valid |

## Verification
The bench builds the controller with 16-bit beats (two byte lanes), a 4-bit address and a 4-bit tag. With these values a bench-side memory model can hold every location, and byte-lane merges that differ between the two beats of a burst can be checked bit for bit. The small address space also lets a read and a write hit the same location in adjacent cycles. This brings the write guard after a read, the undelayed read after a write, and a dropped data-valid strobe within reach of a few directed sequences.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;
  // Half-cycle offsets fixed by the memory's timing
  localparam int BURST      = 2;
  localparam int WR_LEAD    = 2;   // first write beat, half-cycles after command
  localparam int RD_LEAD    = 5;   // first read beat, half-cycles after command
  localparam int PIPE_DEPTH = RD_LEAD + BURST;
  // stages (seen at an issue edge) holding a read that would collide with a new write
  localparam int GUARD_SPAN = RD_LEAD + 1 - WR_LEAD;

  // stage index of a command whose write beat b is driven in the next half-cycle
  function automatic int wr_stage(input int b);
    return WR_LEAD - 1 + b;
  endfunction

  // stage index of a command whose read beat b is on the bus now
  function automatic int rd_stage(input int b);
    return RD_LEAD + b;
  endfunction

  // a write issued now must wait while a recent read is still in flight
  function automatic logic wr_block(input logic [PIPE_DEPTH-1:0] v,
                                    input logic [PIPE_DEPTH-1:0] w);
    logic hit;
    hit = 1'b0;
    for (int s = 0; s <= GUARD_SPAN; s++)
      if (v[s] && !w[s]) hit = 1'b1;
    return hit;
  endfunction
endpackage

// File: rtl/ddr2b_issue.sv
module ddr2b_issue
  import ddr2b_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [PIPE_DEPTH-1:0] st_v,
  input  logic [PIPE_DEPTH-1:0] st_w,
  output logic                  kph,
  output logic                  req_ready,
  output logic                  fire,
  output logic                  wr_blocked
);
  // kph = 1 marks the half-cycle that starts on the main memory edge
  always_ff @(posedge clk) begin
    if (rst) kph <= 1'b0;
    else     kph <= ~kph;
  end

  assign wr_blocked = wr_block(st_v, st_w);
  assign req_ready  = !rst && !kph && !(req_write && wr_blocked);
  assign fire       = req_valid && req_ready;
endmodule

// File: rtl/ddr2b_slot_pipe.sv
module ddr2b_slot_pipe #(
  parameter int DEPTH = 7,
  parameter int PW    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_v,
  input  logic                       in_w,
  input  logic [PW-1:0]              in_p,
  output logic [DEPTH-1:0]           st_v,
  output logic [DEPTH-1:0]           st_w,
  output logic [DEPTH-1:0][PW-1:0]   st_p
);
  // stage s holds the command issued s half-cycles ago
  always_ff @(posedge clk) begin
    if (rst) begin
      st_v <= '0;
      st_w <= '0;
    end else begin
      st_v <= {st_v[DEPTH-2:0], in_v};
      st_w <= {st_w[DEPTH-2:0], in_w};
    end
    st_p[0] <= in_p;
    for (int s = 1; s < DEPTH; s++) st_p[s] <= st_p[s-1];
  end
endmodule

// File: rtl/ddr2b_wr_drive.sv
module ddr2b_wr_drive #(
  parameter int DW    = 16,
  parameter int BW    = 2,
  parameter int NBEAT = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NBEAT-1:0]            sel,
  input  logic [NBEAT-1:0][DW-1:0]    beat_d,
  input  logic [NBEAT-1:0][BW-1:0]    beat_be,
  output logic                        oe,
  output logic [DW-1:0]               dq,
  output logic [BW-1:0]               be
);
  logic          nxt_oe;
  logic [DW-1:0] nxt_d;
  logic [BW-1:0] nxt_be;

  // the guard keeps beat slots disjoint, so at most one sel is high
  always_comb begin
    nxt_oe = 1'b0;
    nxt_d  = '0;
    nxt_be = '0;
    for (int b = 0; b < NBEAT; b++) begin
      if (sel[b]) begin
        nxt_oe = 1'b1;
        nxt_d  = beat_d[b];
        nxt_be = beat_be[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe <= 1'b0;
      dq <= '0;
      be <= '0;
    end else begin
      oe <= nxt_oe;
      dq <= nxt_d;
      be <= nxt_be;
    end
  end
endmodule

// File: rtl/ddr2b_rd_capture.sv
module ddr2b_rd_capture #(
  parameter int DW    = 16,
  parameter int TW    = 4,
  parameter int NBEAT = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NBEAT-1:0]      hit,
  input  logic [TW-1:0]         tag,
  input  logic [DW-1:0]         dq_i,
  input  logic                  qvld,
  output logic                  rsp_valid,
  output logic [NBEAT*DW-1:0]   rsp_data,
  output logic [TW-1:0]         rsp_tag,
  output logic                  rsp_err
);
  logic [NBEAT-2:0][DW-1:0] beat_q;
  logic [NBEAT-2:0]         ok_q;
  logic [NBEAT*DW-1:0]      whole;

  // early beats wait in holding registers until the last one arrives
  for (genvar b = 0; b < NBEAT - 1; b++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst) begin
        beat_q[b] <= '0;
        ok_q[b]   <= 1'b0;
      end else if (hit[b]) begin
        beat_q[b] <= dq_i;
        ok_q[b]   <= qvld;
      end
    end
  end

  assign whole = {dq_i, beat_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_tag   <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= hit[NBEAT-1];
      if (hit[NBEAT-1]) begin
        rsp_data <= whole;
        rsp_tag  <= tag;
        rsp_err  <= !(qvld && (&ok_q));
      end
    end
  end
endmodule

// File: rtl/ddr2b_ctrl.sv
module ddr2b_ctrl
  import ddr2b_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 36,
  parameter int TW = 4,
  parameter int BW = (DW + 7) / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [TW-1:0]     req_tag,
  input  logic [2*DW-1:0]   req_wdata,
  input  logic [2*BW-1:0]   req_be,
  output logic              rsp_valid,
  output logic [2*DW-1:0]   rsp_data,
  output logic [TW-1:0]     rsp_tag,
  output logic              rsp_err,
  output logic              mem_kphase,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_dq_o,
  output logic [BW-1:0]     mem_be,
  output logic              mem_oe,
  input  logic [DW-1:0]     mem_dq_i,
  input  logic              mem_qvld
);
  localparam int BE_LO   = BURST * DW;
  localparam int TAG_LO  = BE_LO + BURST * BW;
  localparam int ADDR_LO = TAG_LO + TW;
  localparam int PW      = ADDR_LO + AW;

  logic [PIPE_DEPTH-1:0]         st_v, st_w;
  logic [PIPE_DEPTH-1:0][PW-1:0] st_p;
  logic                          kph, issue_fire, wr_blocked;
  logic                          bus_wr_slot, bus_rd_slot;
  logic [BURST-1:0]              wr_sel, rd_hit;
  logic [BURST-1:0][DW-1:0]      wr_d;
  logic [BURST-1:0][BW-1:0]      wr_be;

  ddr2b_issue u_issue (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .st_v(st_v), .st_w(st_w), .kph(kph), .req_ready(req_ready),
    .fire(issue_fire), .wr_blocked(wr_blocked)
  );

  ddr2b_slot_pipe #(.DEPTH(PIPE_DEPTH), .PW(PW)) u_pipe (
    .clk(clk), .rst(rst), .in_v(issue_fire), .in_w(req_write),
    .in_p({req_addr, req_tag, req_be, req_wdata}),
    .st_v(st_v), .st_w(st_w), .st_p(st_p)
  );

  // command is on the pins in the half-cycle after acceptance
  assign mem_kphase = kph;
  assign mem_rd     = st_v[0] && !st_w[0];
  assign mem_wr     = st_v[0] && st_w[0];
  assign mem_addr   = st_v[0] ? st_p[0][ADDR_LO +: AW] : '0;

  for (genvar b = 0; b < BURST; b++) begin : g_beat
    assign wr_sel[b] = st_v[wr_stage(b)] && st_w[wr_stage(b)];
    assign wr_d[b]   = st_p[wr_stage(b)][b*DW +: DW];
    assign wr_be[b]  = st_p[wr_stage(b)][BE_LO + b*BW +: BW];
    assign rd_hit[b] = st_v[rd_stage(b)] && !st_w[rd_stage(b)];
  end

  // bus occupancy in the current half-cycle, brought out for the checker
  assign bus_wr_slot = (st_v[WR_LEAD] && st_w[WR_LEAD]) ||
                       (st_v[WR_LEAD+1] && st_w[WR_LEAD+1]);
  assign bus_rd_slot = |rd_hit;

  ddr2b_wr_drive #(.DW(DW), .BW(BW), .NBEAT(BURST)) u_wr (
    .clk(clk), .rst(rst), .sel(wr_sel), .beat_d(wr_d), .beat_be(wr_be),
    .oe(mem_oe), .dq(mem_dq_o), .be(mem_be)
  );

  ddr2b_rd_capture #(.DW(DW), .TW(TW), .NBEAT(BURST)) u_rd (
    .clk(clk), .rst(rst), .hit(rd_hit),
    .tag(st_p[rd_stage(BURST-1)][TAG_LO +: TW]),
    .dq_i(mem_dq_i), .qvld(mem_qvld),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag), .rsp_err(rsp_err)
  );
endmodule

// File: rtl/ddr2b_ctrl_chk.sv
module ddr2b_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic kph,
  input logic req_ready,
  input logic mem_rd,
  input logic mem_wr,
  input logic mem_oe,
  input logic bus_rd_slot,
  input logic bus_wr_slot,
  input logic rsp_valid
);
  // R2
  one_cmd_chk: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));
  // R2
  k_slot_chk: assert property (@(posedge clk) disable iff (rst) (mem_rd || mem_wr) |-> kph);
  // R3
  wr_beat_time_chk: assert property (@(posedge clk) disable iff (rst)
    mem_oe |-> ($past(mem_wr, 2) || $past(mem_wr, 3)));
  // R3
  wr_slot_drive_chk: assert property (@(posedge clk) disable iff (rst) bus_wr_slot |-> mem_oe);
  // R6
  bus_dir_chk: assert property (@(posedge clk) disable iff (rst) !(mem_oe && bus_rd_slot));
  // R5
  rsp_latency_chk: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> $past(mem_rd, 7));
  // R7
  wr_guard_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (!$past(mem_rd, 2) && !$past(mem_rd, 4)));
  // R10
  ready_phase_chk: assert property (@(posedge clk) disable iff (rst) kph |-> !req_ready);
endmodule

bind ddr2b_ctrl ddr2b_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .kph(kph), .req_ready(req_ready),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_oe(mem_oe),
  .bus_rd_slot(bus_rd_slot), .bus_wr_slot(bus_wr_slot), .rsp_valid(rsp_valid)
);

// File: tb/tb_ddr2b_ctrl.sv
`timescale 1ns/1ps
module tb_ddr2b_ctrl;
  localparam int AW = 4, DW = 16, TW = 4, BW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_tag = '0;
  logic [2*DW-1:0] req_wdata = '0;
  logic [2*BW-1:0] req_be = '0;
  logic req_ready, rsp_valid, rsp_err, mem_kphase, mem_rd, mem_wr, mem_oe;
  logic [2*DW-1:0] rsp_data;
  logic [TW-1:0] rsp_tag;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_o;
  logic [BW-1:0] mem_be;
  logic [DW-1:0] mem_dq_i = '0;
  logic mem_qvld = 1'b0;

  ddr2b_ctrl #(.AW(AW), .DW(DW), .TW(TW), .BW(BW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_tag(req_tag),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_tag(rsp_tag), .rsp_err(rsp_err),
    .mem_kphase(mem_kphase), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_be(mem_be), .mem_oe(mem_oe),
    .mem_dq_i(mem_dq_i), .mem_qvld(mem_qvld)
  );

  always #5 clk = ~clk;

  int errs = 0, checks = 0, rsp_cnt = 0, hs = 0;
  int last_rd_hs = 0, last_wr_hs = 0, cmd_par = -1;
  bit ready_prev = 1'b0, drop_next = 1'b0;
  logic [DW-1:0] mm [16][2];
  logic [DW-1:0] ref_mem [16][2];
  bit sw_v [16]; logic [AW-1:0] sw_a [16]; int sw_b [16];
  bit sr_v [16]; logic [AW-1:0] sr_a [16]; int sr_b [16]; bit sr_drop [16];
  int exp_hs_q[$];
  logic [TW-1:0] exp_tag_q[$];
  logic [2*DW-1:0] exp_dat_q[$];
  bit exp_err_q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model and bus monitor, one evaluation per half-cycle
  always @(negedge clk) begin
    int s;
    s = hs % 16;
    if (!rst) begin
      if (sw_v[s]) begin
        chk(mem_oe === 1'b1, "R3 bus driven on write beat", mem_oe, 1);
        for (int i = 0; i < BW; i++)
          if (mem_be[i]) mm[sw_a[s]][sw_b[s]][8*i +: 8] = mem_dq_o[8*i +: 8];
        sw_v[s] = 1'b0;
      end else if (mem_oe) chk(1'b0, "R3 drive outside write beat", 1, 0);
      if (sr_v[s]) begin
        chk(mem_oe === 1'b0, "R6 bus released for read beat", mem_oe, 0);
        mem_dq_i = mm[sr_a[s]][sr_b[s]];
        mem_qvld = !sr_drop[s];
        sr_v[s] = 1'b0;
      end else begin
        mem_dq_i = '0;
        mem_qvld = 1'b0;
      end
      if (mem_rd && mem_wr) chk(1'b0, "R2 read and write together", 1, 0);
      if (mem_rd || mem_wr) begin
        if (cmd_par < 0) cmd_par = hs % 2;
        else chk(hs % 2 == cmd_par, "R2 command half-cycle parity", hs % 2, cmd_par);
      end
      if (mem_wr) begin
        for (int b = 0; b < 2; b++) begin
          sw_v[(hs+2+b)%16] = 1'b1; sw_a[(hs+2+b)%16] = mem_addr; sw_b[(hs+2+b)%16] = b;
        end
        last_wr_hs = hs;
      end
      if (mem_rd) begin
        for (int b = 0; b < 2; b++) begin
          sr_v[(hs+5+b)%16] = 1'b1; sr_a[(hs+5+b)%16] = mem_addr;
          sr_b[(hs+5+b)%16] = b; sr_drop[(hs+5+b)%16] = drop_next;
        end
        drop_next = 1'b0;
        exp_hs_q.push_back(hs + 7);
        last_rd_hs = hs;
      end
      if (req_ready && ready_prev) chk(1'b0, "R10 ready in two adjacent half-cycles", 1, 0);
      ready_prev = req_ready;
      if (rsp_valid) begin
        rsp_cnt++;
        if (exp_tag_q.size() == 0 || exp_hs_q.size() == 0) chk(1'b0, "R8 unexpected response", 1, 0);
        else begin
          int eh; logic [TW-1:0] et; logic [2*DW-1:0] ed; bit ee;
          eh = exp_hs_q.pop_front(); et = exp_tag_q.pop_front();
          ed = exp_dat_q.pop_front(); ee = exp_err_q.pop_front();
          chk(hs == eh, "R5 response half-cycle", hs, eh);
          chk(rsp_tag == et, "R8 response tag order", rsp_tag, et);
          chk(rsp_err == ee, "R9 data-valid error flag", rsp_err, ee);
          if (!ee) chk(rsp_data == ed, "R1 R4 two-beat read data", rsp_data, ed);
        end
      end
    end
    hs++;
  end

  // called at posedge+1; returns at posedge+1 after acceptance
  task automatic send(input bit wr, input logic [AW-1:0] a, input logic [2*DW-1:0] d,
                      input logic [2*BW-1:0] be, input logic [TW-1:0] tag, input bit drop);
    bit acc;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_tag = tag;
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      #1 acc = req_ready;
    end
    if (wr) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < BW; i++)
          if (be[b*BW+i]) ref_mem[a][b][8*i +: 8] = d[b*DW + 8*i +: 8];
    end else begin
      exp_tag_q.push_back(tag);
      exp_dat_q.push_back({ref_mem[a][1], ref_mem[a][0]});
      exp_err_q.push_back(drop);
      drop_next = drop;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    repeat (20) @(posedge clk);
    #1 chk(exp_tag_q.size() == 0 && exp_hs_q.size() == 0, req, exp_tag_q.size(), 0);
  endtask

  task automatic t_reset();
    req_valid = 1'b1; req_write = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk(req_ready == 1'b0, "R10 ready low in reset", req_ready, 0);
    req_valid = 1'b0;
    repeat (8) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(mem_oe == 0 && rsp_valid == 0 && mem_rd == 0 && mem_wr == 0, "R2 idle after reset",
        {mem_oe, rsp_valid, mem_rd, mem_wr}, 0);
  endtask

  task automatic t_basic();
    int n0;
    @(posedge clk); #1;
    n0 = rsp_cnt;
    send(1, 4'd3, 32'hBEEF_CAFE, 4'hF, 4'd0, 0);
    repeat (6) @(posedge clk); #1;
    send(0, 4'd3, '0, '0, 4'd5, 0);
    drain("R1 basic response returned");
    chk(rsp_cnt - n0 == 1, "R1 one response per read", rsp_cnt - n0, 1);
  endtask

  task automatic t_bytes();
    @(posedge clk); #1;
    send(1, 4'd5, 32'hBBBB_AAAA, 4'hF, 4'd0, 0);
    send(1, 4'd5, 32'h5678_1234, 4'b1001, 4'd0, 0);
    repeat (6) @(posedge clk); #1;
    send(0, 4'd5, '0, '0, 4'd6, 0);
    drain("R4 per-beat byte enables");
    chk(ref_mem[5][0] == 16'hAA34 && ref_mem[5][1] == 16'h56BB, "R4 merge reference",
        {ref_mem[5][1], ref_mem[5][0]}, 32'h56BB_AA34);
  endtask

  task automatic t_rd_then_wr();
    @(posedge clk); #1;
    send(0, 4'd5, '0, '0, 4'd7, 0);
    send(1, 4'd5, 32'h0F0F_F0F0, 4'hF, 4'd0, 0);
    drain("R7 read before write sees old data");
    chk(last_wr_hs - last_rd_hs == 6, "R7 write held after read", last_wr_hs - last_rd_hs, 6);
  endtask

  task automatic t_wr_then_rd();
    @(posedge clk); #1;
    send(1, 4'd9, 32'h1357_2468, 4'hF, 4'd0, 0);
    send(0, 4'd9, '0, '0, 4'd8, 0);
    drain("R7 read after write");
    chk(last_rd_hs - last_wr_hs == 2, "R7 read not delayed by write", last_rd_hs - last_wr_hs, 2);
  endtask

  task automatic t_tags();
    int n0;
    @(posedge clk); #1;
    n0 = rsp_cnt;
    for (int k = 0; k < 4; k++) send(0, 4'(k + 2), '0, '0, 4'(9 + k), 0);
    drain("R8 tagged reads in order");
    chk(rsp_cnt - n0 == 4, "R8 four responses", rsp_cnt - n0, 4);
  endtask

  task automatic t_qvld();
    @(posedge clk); #1;
    send(0, 4'd3, '0, '0, 4'd1, 1);
    send(0, 4'd3, '0, '0, 4'd2, 0);
    drain("R9 missing data-valid flagged");
  endtask

  initial begin
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 2; b++) begin mm[a][b] = '0; ref_mem[a][b] = '0; end
    for (int i = 0; i < 16; i++) begin sw_v[i] = 0; sr_v[i] = 0; end
    t_reset();
    t_basic();
    t_bytes();
    t_rd_then_wr();
    t_wr_then_rd();
    t_tags();
    t_qvld();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errs++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule